// File: doc/BRIEF.md
# Leading Non-Zero Detection Tree

This block turns a dense vector of activations into a stream of non-zero (value, column) pairs for a row-partitioned sparse matrix-vector engine. A start command captures the whole activation vector and a scan length. From then on, the block sends the non-zero activations whose column is below the scan length. It sends them one per cycle, in ascending column order, on a single broadcast port shared by every processing-element queue. Zero activations never leave the block, so the engine skips their columns entirely.

Selection is made by a four-ary tree. Each leaf group of four activations finds its own lowest pending non-zero. Each middle node picks the lowest of its four leaf groups. The root picks the lowest middle node. When an entry is sent, only that entry is retired, and every other candidate stays pending. The whole broadcast holds in any cycle where at least one downstream queue reports full. When nothing is left to send, a single-cycle done pulse is raised. The block then stays idle until the next start.

Top module: `nz_quad_tree`

## Requirements
- R1: After a start, the block emits each non-zero activation with column index below `scan_len` exactly once. `bc_val` equals the activation captured at start for column `bc_idx`. Column c occupies bits [16c+15:16c] of `act_vec`.
- R2: Emitted column indices are strictly increasing within one scan. The lowest pending column always wins.
- R3: A zero activation is never emitted.
- R4: If any bit of `q_full` is high at a rising edge, `bc_valid` is low in the following cycle. A stalled entry is emitted later and is not lost.
- R5: No column at or above `scan_len` is emitted. With `scan_len` of 0, no pair is emitted and `done` rises in the cycle after the start edge.
- R6: `done` is a one-cycle pulse. It appears in the cycle directly after the last emission cycle, and `busy` is low while it is high.
- R7: After reset, `bc_valid`, `done` and `busy` are low. After `done`, nothing is emitted until the next start.
- R8: A start given while a scan is in progress discards the old scan and restarts with the newly captured vector and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture vector and length, begin a scan |
| act_vec | input | N_LEAF*4*VAL_W | Dense activation vector, column c at bits [c*VAL_W +: VAL_W] |
| scan_len | input | IDX_W+1 | Number of columns to scan |
| q_full | input | N_PE | Full flags of the downstream queues |
| bc_valid | output | 1 | Broadcast pair valid this cycle |
| bc_val | output | VAL_W | Broadcast activation value |
| bc_idx | output | IDX_W | Broadcast column index |
| done | output | 1 | Scan finished pulse |
| busy | output | 1 | Scan in progress |

## Verification
The bench builds the block with its defaults: 16-bit values, 16 leaf groups (64 columns, three tree levels) and 8 queue flags. At this size every leaf, every middle node and every root input can be exercised. This covers the extreme columns 0 and 63, a full length of 64, and vectors that are entirely zero or entirely non-zero. Random queue-full patterns at several densities, together with a long forced stall, show that stalls delay entries without dropping them. A restart in the middle of a scan is also covered.

// File: rtl/nz_quad_tree.sv
module nz_quad_tree #(
  parameter int VAL_W  = 16,
  parameter int N_LEAF = 16,
  parameter int N_PE   = 8,
  localparam int N_ACT = N_LEAF * 4,
  localparam int N_MID = N_LEAF / 4,
  localparam int RS_W  = (N_MID > 1) ? $clog2(N_MID) : 1,
  localparam int IDX_W = RS_W + 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [N_ACT*VAL_W-1:0] act_vec,
  input  logic [IDX_W:0]         scan_len,
  input  logic [N_PE-1:0]        q_full,
  output logic                   bc_valid,
  output logic [VAL_W-1:0]       bc_val,
  output logic [IDX_W-1:0]       bc_idx,
  output logic                   done,
  output logic                   busy
);

  function automatic logic [1:0] first4(input logic [3:0] v);
    if (v[0])      return 2'd0;
    else if (v[1]) return 2'd1;
    else if (v[2]) return 2'd2;
    else           return 2'd3;
  endfunction

  logic [N_ACT-1:0][VAL_W-1:0] vals;
  logic [N_ACT-1:0]            pend;
  logic [IDX_W:0]              len_r;

  logic [N_LEAF-1:0] leaf_v;
  logic [1:0]        leaf_off [N_LEAF];
  logic [N_MID-1:0]  mid_v;
  logic [1:0]        mid_sel  [N_MID];
  logic [RS_W-1:0]   root_sel;
  logic              root_v;
  logic [RS_W+1:0]   grp;
  logic [IDX_W-1:0]  sel_idx;
  logic              take;

  for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
    assign leaf_v[g]   = |pend[g*4 +: 4];
    assign leaf_off[g] = first4(pend[g*4 +: 4]);
  end

  for (genvar m = 0; m < N_MID; m++) begin : g_mid
    assign mid_v[m]   = |leaf_v[m*4 +: 4];
    assign mid_sel[m] = first4(leaf_v[m*4 +: 4]);
  end

  always_comb begin
    root_sel = '0;
    for (int i = N_MID - 1; i >= 0; i--)
      if (mid_v[i]) root_sel = RS_W'(i);
  end

  assign root_v  = |mid_v;
  assign grp     = {root_sel, mid_sel[root_sel]};
  assign sel_idx = {grp, leaf_off[grp]};
  assign take    = busy && root_v && !(|q_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vals     <= '0;
      pend     <= '0;
      len_r    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      bc_valid <= 1'b0;
      bc_val   <= '0;
      bc_idx   <= '0;
    end else begin
      bc_valid <= 1'b0;
      done     <= 1'b0;
      if (start) begin
        vals  <= act_vec;
        len_r <= scan_len;
        busy  <= 1'b1;
        for (int i = 0; i < N_ACT; i++)
          pend[i] <= (act_vec[i*VAL_W +: VAL_W] != '0) && ((IDX_W+1)'(i) < scan_len);
      end else if (take) begin
        bc_valid      <= 1'b1;
        bc_val        <= vals[sel_idx];
        bc_idx        <= sel_idx;
        pend[sel_idx] <= 1'b0;
      end else if (busy && !root_v) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  logic [IDX_W-1:0] last_idx;
  logic             seen;
  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      seen     <= 1'b0;
      last_idx <= '0;
    end else if (bc_valid) begin
      seen     <= 1'b1;
      last_idx <= bc_idx;
    end
  end

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && seen) |-> (bc_idx > last_idx));
  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> (bc_val != '0));
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_full) |=> !bc_valid);
  p_in_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> ({1'b0, bc_idx} < len_r));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bc_valid));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bc_valid);

endmodule

// File: tb/nz_quad_tree_bench.sv
module nz_quad_tree_bench;
  localparam int CLK_P = 10;
  localparam int VW    = 16;
  localparam int NA    = 64;
  localparam int NPE   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NA*VW-1:0] act_vec = '0;
  logic [6:0] scan_len = '0;
  logic [NPE-1:0] q_full = '0;
  logic bc_valid, done, busy;
  logic [VW-1:0] bc_val;
  logic [5:0] bc_idx;

  always #(CLK_P/2) clk = ~clk;

  nz_quad_tree u_nz_quad_tree (
    .clk(clk), .rst_n(rst_n), .start(start), .act_vec(act_vec),
    .scan_len(scan_len), .q_full(q_full), .bc_valid(bc_valid),
    .bc_val(bc_val), .bc_idx(bc_idx), .done(done), .busy(busy));

  int n_run = 0;
  int n_fail = 0;
  logic [VW-1:0] acts [NA];
  logic [VW-1:0] exp_val [NA];
  int exp_idx [NA];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int build_exp(input int len);
    int n = 0;
    for (int i = 0; i < NA; i++)
      if (i < len && acts[i] != 0) begin
        exp_val[n] = acts[i];
        exp_idx[n] = i;
        n++;
      end
    return n;
  endfunction

  task automatic pack_acts();
    for (int i = 0; i < NA; i++) act_vec[i*VW +: VW] = acts[i];
  endtask

  task automatic fill(input int zero_pct);
    for (int i = 0; i < NA; i++)
      acts[i] = (($urandom % 100) < zero_pct) ? 16'h0 : VW'(($urandom % 65535) + 1);
  endtask

  task automatic run_case(input int len, input int stall_pct, input int hold_cycles);
    int n_exp, k, cyc;
    bit prev_full, prev_valid, got_done;
    pack_acts();
    n_exp = build_exp(len);
    scan_len = 7'(len);
    start = 1'b1;
    q_full = '0;
    @(negedge clk);
    start = 1'b0;
    if (hold_cycles > 0) q_full = 8'h01;
    prev_full = (hold_cycles > 0);
    prev_valid = 1'b0;
    @(negedge clk);
    k = 0;
    cyc = 0;
    got_done = 1'b0;
    while (cyc < 3000) begin
      if (prev_full) chk(!bc_valid, "R4 stall", int'(bc_valid), 0);
      if (bc_valid) begin
        if (k < n_exp) begin
          chk(int'(bc_idx) == exp_idx[k], "R1/R2/R5 index", int'(bc_idx), exp_idx[k]);
          chk(bc_val == exp_val[k], "R1/R3 value", int'(bc_val), int'(exp_val[k]));
        end else chk(1'b0, "R1 extra emission", int'(bc_idx), -1);
        k++;
      end
      if (done) begin
        got_done = 1'b1;
        chk(!busy, "R6 busy low at done", int'(busy), 0);
        if (n_exp > 0) chk(prev_valid, "R6 done right after last emission", int'(prev_valid), 1);
        else chk(cyc == 0, "R5 done after empty scan", cyc, 0);
        break;
      end
      prev_valid = bc_valid;
      cyc++;
      if (cyc < hold_cycles) q_full = 8'h80;
      else q_full = (($urandom % 100) < stall_pct) ? NPE'($urandom % 255 + 1) : '0;
      prev_full = |q_full;
      @(negedge clk);
    end
    chk(got_done, "R6 done seen", int'(got_done), 1);
    chk(k == n_exp, "R1 emission count", k, n_exp);
    q_full = '0;
    @(negedge clk);
    chk(!done && !busy && !bc_valid, "R6/R7 idle after done", int'({done, busy, bc_valid}), 0);
    @(negedge clk);
    chk(!bc_valid, "R7 quiet until next start", int'(bc_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bc_valid && !done && !busy, "R7 reset state", int'({bc_valid, done, busy}), 0);

    for (int i = 0; i < NA; i++) acts[i] = '0;
    run_case(64, 0, 0);                          // R3 all zero
    for (int i = 0; i < NA; i++) acts[i] = VW'(i + 1);
    run_case(64, 0, 0);                          // R2 dense, full length
    run_case(0, 0, 0);                           // R5 zero length
    run_case(37, 30, 0);                         // R5 partial length
    for (int i = 0; i < NA; i++) acts[i] = '0;
    acts[63] = 16'h8000;
    run_case(64, 0, 0);                          // R1 last column only
    run_case(63, 0, 0);                          // R5 last column excluded
    acts[63] = '0;
    acts[0] = 16'h0001;
    run_case(64, 0, 0);                          // R1 first column only
    fill(50);
    run_case(64, 20, 25);                        // R4 long forced stall
    fill(30);
    run_case(64, 90, 0);                         // R4 heavy stall

    fill(10);                                    // R8 restart mid-scan
    pack_acts();
    scan_len = 7'd64;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    fill(60);
    run_case(50, 10, 0);

    for (int t = 0; t < 20; t++) begin
      fill(int'($urandom % 100));
      run_case(int'($urandom % 65), int'($urandom % 60), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule